// File: doc/BRIEF.md
# Serial Transceiver with Three-Point Bit Voting

This block is an asynchronous serial transmitter and receiver that runs from the system clock. A programmable divider produces a tick at sixteen times the bit rate. Both directions use that tick. The transmitter turns one byte into a frame: a start bit, the data bits least significant first, an optional parity bit, and a stop bit. It holds the line high between frames.

The receiver watches the incoming line through a two-stage synchroniser. A low level seen on a tick is treated as a possible start bit. Every bit of the frame, including the start and stop bits, is sampled on three consecutive oversample ticks around its centre. The bit value is the majority of those three samples. When the three samples of any bit disagree, the frame is marked as noisy. A completed byte is placed in a one-entry holding register together with its noise, framing and parity flags. It stays there until the consumer takes it. A typical configuration runs at 57600 bit/s, with the divider chosen from the system clock.

Top module: `serial_tri_uart`

## Requirements
- R1: After a synchronous reset, the transmit line is high, `tx_busy` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: The oversample tick fires once every `baud_div`+1 clocks. Every transmitted bit lasts exactly 16 ticks, counted from the first tick after the byte is accepted.
- R3: A byte is accepted when `tx_valid` and `tx_ready` are both 1. The frame is sent as follows: a start bit (0), then data bit 0 through data bit 7, then a parity bit when `par_en`=1, then a stop bit (1). `tx_busy` is 1 from the accept edge through the last tick of the stop bit. `tx_ready` equals the inverse of `tx_busy`.
- R4: With `par_odd`=0 the parity bit makes the count of ones in data plus parity even. With `par_odd`=1 it makes that count odd.
- R5: The receiver treats the tick on which it first sees a low line as tick 0 of the start bit. It samples each bit on ticks 7, 8 and 9 of that bit and takes the majority of the three samples as the bit value.
- R6: If the three samples of any bit in a frame disagree, `rx_noise_err` is 1 for that byte. This covers the start, data, parity and stop bits. The delivered data still follows the majority.
- R7: If the majority value of a start bit is 1, the receiver returns to idle and delivers no byte.
- R8: A stop bit whose majority value is 0 sets `rx_frame_err`. The byte is still delivered.
- R9: With `par_en`=1, a received parity bit that does not match the selected even or odd rule sets `rx_par_err`. With `par_en`=0, `rx_par_err` stays 0.
- R10: `rx_valid`, `rx_data` and the error flags hold steady until `rx_ready` is 1. In the cycle after the handshake, `rx_valid` and the flags are 0. A byte that completes while the previous one is still unread is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_div | input | 16 | Oversample divider; tick period is baud_div+1 clocks |
| par_en | input | 1 | Adds and checks a parity bit when 1 |
| par_odd | input | 1 | Selects odd parity when 1, even when 0 |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_line | output | 1 | Serial output line |
| tx_busy | output | 1 | A frame is being sent |
| rx_line | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_noise_err | output | 1 | Sample disagreement somewhere in the frame |
| rx_frame_err | output | 1 | Stop bit read as 0 |
| rx_par_err | output | 1 | Parity mismatch |

## Verification
A wrong divider count or bit counter in the transmitter shows up on `tx_line` within one oversample tick of the bit edge where it goes wrong. A cycle-accurate model of the line and busy flag catches it on that same clock. In the receiver, a sample point shifted by even one tick changes the outcome of a glitch placed on a single middle sample. The noise flag or the data of that very byte then differs, and this is visible as soon as `rx_valid` rises. A wrong majority, parity or stop decision is visible on the flags of the byte it affects. A lost handshake shows as `rx_valid` staying high one cycle after `rx_ready`.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    localparam int OS_RATE  = 16;
    localparam int OS_W     = $clog2(OS_RATE);
    localparam int SAMP_LO  = 7;
    localparam int SAMP_MID = 8;
    localparam int SAMP_HI  = 9;
    localparam int OS_LAST  = OS_RATE - 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic noise;
        logic frame;
        logic parity;
    } rx_err_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

endpackage

// File: rtl/tsu_baud_tick.sv
module tsu_baud_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/tsu_tx.sv
module tsu_tx
    import tsu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              line,
    output logic              busy
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    phase_e            ph;
    logic [OS_W-1:0]   os;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              parbit;

    assign busy  = (ph != PH_IDLE);
    assign ready = !busy;

    always_comb begin
        case (ph)
            PH_START: line = 1'b0;
            PH_DATA:  line = shreg[0];
            PH_PAR:   line = parbit;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            os     <= '0;
            idx    <= '0;
            shreg  <= '0;
            parbit <= 1'b0;
        end else if (ph == PH_IDLE) begin
            if (valid) begin
                shreg  <= data;
                parbit <= (^data) ^ par_odd;
                os     <= '0;
                idx    <= '0;
                ph     <= PH_START;
            end
        end else if (tick) begin
            if (os == OS_W'(OS_LAST)) begin
                os <= '0;
                case (ph)
                    PH_START: begin
                        ph  <= PH_DATA;
                        idx <= '0;
                    end
                    PH_DATA: begin
                        shreg <= shreg >> 1;
                        if (idx == IDX_W'(DATA_W - 1)) begin
                            ph <= par_en ? PH_PAR : PH_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    PH_PAR:  ph <= PH_STOP;
                    default: ph <= PH_IDLE;
                endcase
            end else begin
                os <= os + 1'b1;
            end
        end
    end

    // R3
    tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> (busy && !line));

    // R2
    tx_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(line));

endmodule

// File: rtl/tsu_rx.sv
module tsu_rx
    import tsu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line_in,
    input  logic              par_en,
    input  logic              par_odd,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    input  logic              ready,
    output rx_err_t           err
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic              sync1, sync2;
    phase_e            ph;
    logic [OS_W-1:0]   os;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              s_lo, s_mid, s_hi;
    logic              noise_acc;
    logic              parbit;

    logic third, bit_val, bit_bad, stop_done;

    assign third     = (ph == PH_STOP) ? sync2 : s_hi;
    assign bit_val   = maj3(s_lo, s_mid, third);
    assign bit_bad   = split3(s_lo, s_mid, third);
    assign stop_done = tick && (ph == PH_STOP) && (os == OS_W'(SAMP_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_in;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            os        <= '0;
            idx       <= '0;
            shreg     <= '0;
            s_lo      <= 1'b1;
            s_mid     <= 1'b1;
            s_hi      <= 1'b1;
            noise_acc <= 1'b0;
            parbit    <= 1'b0;
        end else if (tick) begin
            if (ph == PH_IDLE) begin
                if (!sync2) begin
                    ph        <= PH_START;
                    os        <= OS_W'(1);
                    noise_acc <= 1'b0;
                end
            end else begin
                if (os == OS_W'(SAMP_LO))  s_lo  <= sync2;
                if (os == OS_W'(SAMP_MID)) s_mid <= sync2;
                if (os == OS_W'(SAMP_HI))  s_hi  <= sync2;
                if (stop_done) begin
                    ph <= PH_IDLE;
                    os <= '0;
                end else if (os == OS_W'(OS_LAST)) begin
                    os        <= '0;
                    noise_acc <= noise_acc | bit_bad;
                    case (ph)
                        PH_START: begin
                            ph  <= bit_val ? PH_IDLE : PH_DATA;
                            idx <= '0;
                        end
                        PH_DATA: begin
                            shreg <= {bit_val, shreg[DATA_W-1:1]};
                            if (idx == IDX_W'(DATA_W - 1)) begin
                                ph <= par_en ? PH_PAR : PH_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                        default: begin
                            parbit <= bit_val;
                            ph     <= PH_STOP;
                        end
                    endcase
                end else begin
                    os <= os + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
            err   <= '0;
        end else if (valid) begin
            if (ready) begin
                valid <= 1'b0;
                err   <= '0;
            end
        end else if (stop_done) begin
            data       <= shreg;
            valid      <= 1'b1;
            err.noise  <= noise_acc | bit_bad;
            err.frame  <= !bit_val;
            err.parity <= par_en && (parbit != ((^shreg) ^ par_odd));
        end
    end

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(data) && $stable(err)));

    // R10
    rx_release_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !valid);

    // R6
    rx_flag_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (err != '0) |-> valid);

endmodule

// File: rtl/serial_tri_uart.sv
module serial_tri_uart
    import tsu_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    output logic              tx_busy,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_noise_err,
    output logic              rx_frame_err,
    output logic              rx_par_err
);
    logic    tick;
    rx_err_t rx_err;

    tsu_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (baud_div),
        .tick (tick)
    );

    tsu_tx #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .par_en  (par_en),
        .par_odd (par_odd),
        .data    (tx_data),
        .valid   (tx_valid),
        .ready   (tx_ready),
        .line    (tx_line),
        .busy    (tx_busy)
    );

    tsu_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .line_in (rx_line),
        .par_en  (par_en),
        .par_odd (par_odd),
        .data    (rx_data),
        .valid   (rx_valid),
        .ready   (rx_ready),
        .err     (rx_err)
    );

    assign rx_noise_err = rx_err.noise;
    assign rx_frame_err = rx_err.frame;
    assign rx_par_err   = rx_err.parity;

endmodule

// File: tb/serial_tri_uart_tb.sv
module serial_tri_uart_tb;

    typedef bit bitq_t[$];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] baud_div = 16'd3;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_line, tx_busy;
    logic        rx_line = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic        rx_noise_err, rx_frame_err, rx_par_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    serial_tri_uart u_dut (
        .clk          (clk),
        .rst          (rst),
        .baud_div     (baud_div),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_line      (tx_line),
        .tx_busy      (tx_busy),
        .rx_line      (rx_line),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .rx_noise_err (rx_noise_err),
        .rx_frame_err (rx_frame_err),
        .rx_par_err   (rx_par_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bitq_t frame_bits(input logic [7:0] d, input bit pe, input bit po);
        bitq_t q;
        q.push_back(1'b0);
        for (int i = 0; i < 8; i++) q.push_back(d[i]);
        if (pe) q.push_back((^d) ^ po);
        q.push_back(1'b1);
        return q;
    endfunction

    // behavioural reference: divider and transmitter
    int    m_cnt  = 0;
    bit    m_busy = 1'b0;
    bit    m_line = 1'b1;
    int    m_sub  = 0;
    bit    m_tk;
    bitq_t m_q;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_busy = 1'b0;
            m_line = 1'b1;
            m_sub  = 0;
            m_q.delete();
        end else begin
            m_tk = (m_cnt == int'(baud_div));
            if (!m_busy && tx_valid) begin
                m_q    = frame_bits(tx_data, par_en, par_odd);
                m_busy = 1'b1;
                m_line = m_q[0];
                m_sub  = 0;
            end else if (m_busy && m_tk) begin
                if (m_sub == 15) begin
                    void'(m_q.pop_front());
                    m_sub = 0;
                    if (m_q.size() == 0) begin
                        m_busy = 1'b0;
                        m_line = 1'b1;
                    end else begin
                        m_line = m_q[0];
                    end
                end else begin
                    m_sub++;
                end
            end
            m_cnt = m_tk ? 0 : m_cnt + 1;
        end
    end

    // per-clock comparison of the transmit side
    always @(negedge clk) begin
        if (!rst) begin
            chk(tx_line === m_line, "R2 R3 R4", "tx_line", int'(tx_line), int'(m_line));
            chk(tx_busy === m_busy, "R3", "tx_busy", int'(tx_busy), int'(m_busy));
            chk(tx_ready === !m_busy, "R3", "tx_ready", int'(tx_ready), int'(!m_busy));
        end
    end

    task automatic tx_send(input logic [7:0] d, input bit pe, input bit po);
        par_en   = pe;
        par_odd  = po;
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic rx_drive(input logic [7:0] d, input bit pe, input bit po,
                            input bit flip_par, input int glitch_bit, input bit stop_v);
        bitq_t b;
        int t;
        int p;
        b = frame_bits(d, pe, po);
        if (flip_par && pe) b[9] = ~b[9];
        b[b.size() - 1] = stop_v;
        t = int'(baud_div) + 1;
        p = 16 * t;
        par_en  = pe;
        par_odd = po;
        do @(negedge clk); while (m_cnt != int'(baud_div));
        for (int j = 0; j < b.size() * p; j++) begin
            logic v;
            v = b[j / p];
            if ((j / p) == glitch_bit && (j % p) >= 9 * t - 3 && (j % p) <= 9 * t - 1) v = ~v;
            rx_line = v;
            @(negedge clk);
        end
        rx_line = 1'b1;
    endtask

    task automatic rx_expect(input logic [7:0] d, input bit nz, input bit fr, input bit pr,
                             input string req);
        int p;
        p = 16 * (int'(baud_div) + 1);
        chk(rx_valid === 1'b1, req, "rx_valid", int'(rx_valid), 1);
        chk(rx_data === d, req, "rx_data", int'(rx_data), int'(d));
        chk(rx_noise_err === nz, req, "rx_noise_err", int'(rx_noise_err), int'(nz));
        chk(rx_frame_err === fr, req, "rx_frame_err", int'(rx_frame_err), int'(fr));
        chk(rx_par_err === pr, req, "rx_par_err", int'(rx_par_err), int'(pr));
        repeat (20) @(negedge clk);
        // R10: held while unread
        chk(rx_valid === 1'b1 && rx_data === d, "R10", "rx hold", int'(rx_data), int'(d));
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        // R10: released after handshake
        chk(rx_valid === 1'b0, "R10", "rx_valid after take", int'(rx_valid), 0);
        chk(rx_noise_err === 1'b0 && rx_frame_err === 1'b0, "R10", "flags after take",
            int'({rx_noise_err, rx_frame_err}), 0);
        repeat (2 * p) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int p;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        // R1
        chk(tx_line === 1'b1, "R1", "tx_line reset", int'(tx_line), 1);
        chk(tx_busy === 1'b0, "R1", "tx_busy reset", int'(tx_busy), 0);
        chk(tx_ready === 1'b1, "R1", "tx_ready reset", int'(tx_ready), 1);
        chk(rx_valid === 1'b0, "R1", "rx_valid reset", int'(rx_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // transmitter: R2 R3 R4 via cycle model
        tx_send(8'hA5, 1'b0, 1'b0);
        tx_send(8'h3C, 1'b1, 1'b0);
        tx_send(8'h3C, 1'b1, 1'b1);
        tx_send(8'h01, 1'b1, 1'b1);
        tx_send(8'hFE, 1'b0, 1'b0);

        // receiver
        rx_drive(8'hA5, 1'b0, 1'b0, 1'b0, -1, 1'b1);
        rx_expect(8'hA5, 1'b0, 1'b0, 1'b0, "R5");
        rx_drive(8'h3C, 1'b1, 1'b0, 1'b0, -1, 1'b1);
        rx_expect(8'h3C, 1'b0, 1'b0, 1'b0, "R4 R9");
        rx_drive(8'h96, 1'b1, 1'b1, 1'b1, -1, 1'b1);
        rx_expect(8'h96, 1'b0, 1'b0, 1'b1, "R9");
        rx_drive(8'h81, 1'b0, 1'b0, 1'b0, 4, 1'b1);
        rx_expect(8'h81, 1'b1, 1'b0, 1'b0, "R5 R6 data");
        rx_drive(8'h5A, 1'b0, 1'b0, 1'b0, 0, 1'b1);
        rx_expect(8'h5A, 1'b1, 1'b0, 1'b0, "R6 start");
        rx_drive(8'h77, 1'b1, 1'b0, 1'b0, 10, 1'b1);
        rx_expect(8'h77, 1'b1, 1'b0, 1'b0, "R6 stop");
        rx_drive(8'h42, 1'b0, 1'b0, 1'b0, -1, 1'b0);
        rx_expect(8'h42, 1'b0, 1'b1, 1'b0, "R8");

        // R7: short low pulse, majority high at start samples
        p = 16 * (int'(baud_div) + 1);
        do @(negedge clk); while (m_cnt != int'(baud_div));
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * p) @(negedge clk);
        chk(rx_valid === 1'b0, "R7", "rx_valid after false start", int'(rx_valid), 0);
        rx_drive(8'hC3, 1'b0, 1'b0, 1'b0, -1, 1'b1);
        rx_expect(8'hC3, 1'b0, 1'b0, 1'b0, "R7 recovery");

        // second divider setting
        rst = 1'b1;
        baud_div = 16'd5;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        tx_send(8'h5A, 1'b1, 1'b0);
        rx_drive(8'hC3, 1'b1, 1'b1, 1'b0, 6, 1'b1);
        rx_expect(8'hC3, 1'b1, 1'b0, 1'b0, "R2 R5 R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule